// File: doc/BRIEF.md
# Scaled FP4 Micro-Block Dot-Product Accumulator

This block takes two blocks of sixteen 4-bit floating-point elements (1 sign, 2 exponent and 1 mantissa bit). Each block comes with its own 8-bit floating-point scale (1 sign, 4 exponent and 3 mantissa bits, bias 7). The block forms the exact dot product of the two element vectors. It multiplies that result by both scales and adds it into a running single-precision (IEEE 754 binary32) accumulator. The element products and their sum are kept exact in fixed point. The scale multiply is also exact. The only rounding happens when the scaled value is added into the accumulator, and that rounding is to nearest, ties to even.

A caller starts a new reduction by raising `clr` together with the first pair of blocks, or raises `clr` alone to zero the accumulator. Each cycle with `in_valid` high adds one block pair. One cycle later the updated sum appears on `acc_out`, and `acc_valid` pulses for that cycle. The accumulator keeps its value between valid cycles. A scale code that encodes NaN makes the accumulator NaN until the next clear.

Top module: `fp4_block_dot`

## Requirements
- R1: Element i of a block lies at bits [4i+3:4i]. Bit 3 is the sign, bits [2:1] are the exponent and bit 0 is the mantissa. Exponent 0 gives the value m*0.5. Any other exponent e gives the value (1+m/2)*2^(e-1), so magnitudes come from {0, 0.5, 1, 1.5, 2, 3, 4, 6}.
- R2: The block dot product is the exact sum of the 16 element products, with no rounding before the accumulate step.
- R3: A scale code has its sign at bit 7, its exponent at bits [6:3] and its mantissa at bits [2:0]. Exponent 0 gives the value (m/8)*2^-6 (subnormal). Any other exponent e gives the value (1+m/8)*2^(e-7). Both scales multiply the dot product exactly.
- R4: On each valid cycle, the accumulator becomes the binary32 sum of its old value and the scaled block value, rounded to nearest with ties to even.
- R5: `clr` without `in_valid` sets the accumulator to +0 (32'h00000000). `clr` with `in_valid` sets it to +0 plus the scaled block value.
- R6: `acc_valid` is high exactly in the cycle after a cycle with `in_valid` high. `acc_out` changes only in the cycle after `in_valid` or `clr`.
- R7: A scale code whose bits [6:0] are all ones is NaN. A valid cycle carrying one sets the accumulator to 32'h7FC00000, and the accumulator stays at that value until a clear.
- R8: A negative-zero element contributes zero. A block whose exact sum is zero leaves a nonzero accumulator unchanged. An exact cancellation yields +0, and the accumulator never holds -0.
- R9: After reset, `acc_out` is 32'h00000000 and `acc_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Zero the accumulator, or restart it with the current block pair |
| in_valid | input | 1 | Block pair and scales are valid this cycle |
| a_elems | input | 4*NUM_ELEM | Packed FP4 elements of operand A |
| b_elems | input | 4*NUM_ELEM | Packed FP4 elements of operand B |
| a_scale | input | 8 | 8-bit float scale of operand A |
| b_scale | input | 8 | 8-bit float scale of operand B |
| acc_out | output | 32 | Registered binary32 accumulator |
| acc_valid | output | 1 | Pulses one cycle after each valid input |

## Verification
The bench builds the block with the default of sixteen elements per block. At that width the exact lane sum can reach 2304 quarter units. With both scales near 2^8, a single block can lift the accumulator to 2^24, where the spacing between binary32 values is 2. Small integer blocks added at that magnitude therefore land exactly on rounding ties, and round-half-even can be observed directly. With the same width, subnormal and negative scales, exact cancellation and negative-zero lanes can all be reached within a few cycles.

// File: rtl/fp4dot_pkg.sv
package fp4dot_pkg;

   localparam logic [31:0] F32_QNAN = 32'h7FC0_0000;

   // FP4 code -> signed value in units of one half
   function automatic logic signed [4:0] e2m1_halves(input logic [3:0] code);
      logic [4:0]        mag;
      logic signed [4:0] val;
      if (code[2:1] == 2'd0) mag = {4'd0, code[0]};
      else                   mag = {3'd0, 1'b1, code[0]} << (code[2:1] - 2'd1);
      val = signed'(mag);
      return code[3] ? -val : val;
   endfunction

   // count of zeros above the first one, 27 when all zero
   function automatic logic [4:0] lead_zeros27(input logic [26:0] v);
      logic [4:0] n;
      logic       found;
      n     = 5'd27;
      found = 1'b0;
      for (int i = 26; i >= 0; i--) begin
         if (!found && v[i]) begin
            n     = 5'(26 - i);
            found = 1'b1;
         end
      end
      return n;
   endfunction

endpackage

// File: rtl/fp4_dot_tree.sv
module fp4_dot_tree import fp4dot_pkg::*; #(
   parameter int NUM_ELEM = 16,
   parameter int SUM_W    = 14
) (
   input  logic [4*NUM_ELEM-1:0]  a_elems,
   input  logic [4*NUM_ELEM-1:0]  b_elems,
   output logic signed [SUM_W-1:0] dot
);

   // each product is exact in quarter units, |p| <= 144
   logic signed [9:0] prod [NUM_ELEM];

   for (genvar gi = 0; gi < NUM_ELEM; gi++) begin : g_lane
      logic signed [4:0] ha;
      logic signed [4:0] hb;
      assign ha       = e2m1_halves(a_elems[4*gi +: 4]);
      assign hb       = e2m1_halves(b_elems[4*gi +: 4]);
      assign prod[gi] = 10'(ha) * 10'(hb);
   end

   always_comb begin
      dot = '0;
      for (int i = 0; i < NUM_ELEM; i++) begin
         dot = dot + SUM_W'(prod[i]);
      end
   end

endmodule

// File: rtl/e4m3_scale_pair.sv
module e4m3_scale_pair (
   input  logic [7:0] a_scale,
   input  logic [7:0] b_scale,
   output logic [7:0] sig_prod,
   output logic [4:0] exp_sum,
   output logic       neg,
   output logic       nan
);

   logic [3:0] sig [2];
   logic [3:0] ex  [2];

   for (genvar gk = 0; gk < 2; gk++) begin : g_op
      logic [7:0] code;
      assign code    = (gk == 0) ? a_scale : b_scale;
      assign sig[gk] = {|code[6:3], code[2:0]};
      assign ex[gk]  = (code[6:3] == 4'd0) ? 4'd1 : code[6:3];
   end

   // value = sig_prod * 2^(exp_sum - 20)
   always_comb begin
      sig_prod = 8'(sig[0]) * 8'(sig[1]);
      exp_sum  = 5'(ex[0]) + 5'(ex[1]);
      neg      = a_scale[7] ^ b_scale[7];
      nan      = (&a_scale[6:0]) | (&b_scale[6:0]);
   end

endmodule

// File: rtl/fp32_scaled_add.sv
module fp32_scaled_add import fp4dot_pkg::*; (
   input  logic [31:0] acc_in,
   input  logic        y_neg,
   input  logic [23:0] y_mag,
   input  logic [4:0]  y_esum,
   input  logic        y_nan,
   output logic [31:0] sum_out
);

   logic [4:0]        lz_y, lz_n;
   logic [7:0]        x_e, y_e, big_e, sm_e, diff;
   logic [23:0]       x_m, y_m, big_m, sm_m;
   logic              x_nan, x_inf, swap, big_s, sm_s, eff_sub, rnd_up;
   logic [26:0]       sm_ext, sm_shr, sm_lost, al, norm;
   logic [27:0]       raw;
   logic signed [9:0] e_pre, e_fin;
   logic [24:0]       m_rnd;

   always_comb begin
      x_e   = acc_in[30:23];
      x_m   = {x_e != 8'd0, acc_in[22:0]};
      x_nan = (x_e == 8'hFF) && (acc_in[22:0] != 23'd0);
      x_inf = (x_e == 8'hFF) && (acc_in[22:0] == 23'd0);

      // normalise the exact scaled block value: mag * 2^(esum-22)
      lz_y = lead_zeros27({y_mag, 3'b000});
      y_m  = y_mag << lz_y;
      y_e  = (y_mag == 24'd0) ? 8'd0 : 8'(9'(y_esum) + 9'd128 - 9'(lz_y));

      swap  = {y_e, y_m} > {x_e, x_m};
      big_e = swap ? y_e : x_e;
      big_m = swap ? y_m : x_m;
      big_s = swap ? y_neg : acc_in[31];
      sm_e  = swap ? x_e : y_e;
      sm_m  = swap ? x_m : y_m;
      sm_s  = swap ? acc_in[31] : y_neg;

      diff   = big_e - sm_e;
      sm_ext = {sm_m, 3'b000};
      if (diff >= 8'd27) begin
         sm_shr  = '0;
         sm_lost = sm_ext;
      end else begin
         sm_shr  = sm_ext >> diff;
         sm_lost = sm_ext & ((27'd1 << diff) - 27'd1);
      end
      al = {sm_shr[26:1], sm_shr[0] | (|sm_lost)};

      eff_sub = big_s ^ sm_s;
      raw = eff_sub ? ({1'b0, big_m, 3'b000} - {1'b0, al})
                    : ({1'b0, big_m, 3'b000} + {1'b0, al});

      lz_n = lead_zeros27(raw[26:0]);
      if (raw[27]) begin
         norm  = {raw[27:2], raw[1] | raw[0]};
         e_pre = $signed({2'b00, big_e}) + 10'sd1;
      end else begin
         norm  = raw[26:0] << lz_n;
         e_pre = $signed({2'b00, big_e}) - $signed({5'b00000, lz_n});
      end

      rnd_up = norm[2] & (norm[1] | norm[0] | norm[3]);
      m_rnd  = {1'b0, norm[26:3]} + 25'(rnd_up);
      e_fin  = m_rnd[24] ? (e_pre + 10'sd1) : e_pre;

      if (x_nan || y_nan)         sum_out = F32_QNAN;
      else if (x_inf)             sum_out = acc_in;
      else if (raw == 28'd0)      sum_out = 32'h0;
      else if (e_fin >= 10'sd255) sum_out = {big_s, 8'hFF, 23'h0};
      else if (e_fin <= 10'sd0)   sum_out = 32'h0;
      else sum_out = {big_s, e_fin[7:0], m_rnd[24] ? 23'h0 : m_rnd[22:0]};
   end

endmodule

// File: rtl/fp4_block_dot.sv
module fp4_block_dot import fp4dot_pkg::*; #(
   parameter int NUM_ELEM = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  in_valid,
   input  logic [4*NUM_ELEM-1:0] a_elems,
   input  logic [4*NUM_ELEM-1:0] b_elems,
   input  logic [7:0]            a_scale,
   input  logic [7:0]            b_scale,
   output logic [31:0]           acc_out,
   output logic                  acc_valid
);

   localparam int PROD_MAX = 144;
   localparam int SUM_W    = $clog2(NUM_ELEM * PROD_MAX + 1) + 2;
   localparam int MAG_W    = SUM_W - 1 + 8;

   if (NUM_ELEM < 1 || NUM_ELEM > 512) begin : g_bad_num_elem
      $error("fp4_block_dot: NUM_ELEM must lie in 1..512");
   end

   logic signed [SUM_W-1:0] dot;
   logic [7:0]              sig_prod;
   logic [4:0]              exp_sum;
   logic                    sc_neg, sc_nan;
   logic [SUM_W-2:0]        dot_abs;
   logic [MAG_W-1:0]        mag_full;
   logic [23:0]             y_mag;
   logic [31:0]             acc_q, acc_base, acc_next;
   logic                    vld_q;

   fp4_dot_tree #(.NUM_ELEM(NUM_ELEM), .SUM_W(SUM_W)) u_tree (
      .a_elems (a_elems),
      .b_elems (b_elems),
      .dot     (dot)
   );

   e4m3_scale_pair u_scale (
      .a_scale  (a_scale),
      .b_scale  (b_scale),
      .sig_prod (sig_prod),
      .exp_sum  (exp_sum),
      .neg      (sc_neg),
      .nan      (sc_nan)
   );

   always_comb begin
      dot_abs  = dot[SUM_W-1] ? (SUM_W-1)'(-dot) : (SUM_W-1)'(dot);
      mag_full = MAG_W'(dot_abs) * MAG_W'(sig_prod);
      y_mag    = 24'(mag_full);
      acc_base = clr ? 32'h0 : acc_q;
   end

   fp32_scaled_add u_add (
      .acc_in  (acc_base),
      .y_neg   (dot[SUM_W-1] ^ sc_neg),
      .y_mag   (y_mag),
      .y_esum  (exp_sum),
      .y_nan   (sc_nan),
      .sum_out (acc_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= 32'h0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= in_valid;
         if (in_valid)  acc_q <= acc_next;
         else if (clr)  acc_q <= 32'h0;
      end
   end

   assign acc_out   = acc_q;
   assign acc_valid = vld_q;

endmodule

// File: rtl/fp4_block_dot_chk.sv
module fp4_block_dot_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        clr,
   input logic        in_valid,
   input logic [7:0]  a_scale,
   input logic [7:0]  b_scale,
   input logic [31:0] acc_out,
   input logic        acc_valid
);

   a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> acc_valid);

   a_r6_valid_only: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !acc_valid);

   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !clr) |=> $stable(acc_out));

   a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !in_valid) |=> (acc_out == 32'h0));

   a_r7_nan_enters: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ((&a_scale[6:0]) || (&b_scale[6:0]))) |=> (acc_out == 32'h7FC0_0000));

   a_r7_nan_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_out == 32'h7FC0_0000 && !clr) |=> (acc_out == 32'h7FC0_0000));

   a_r8_no_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
      acc_out != 32'h8000_0000);

   a_r4_no_subnormal: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_out[30:23] == 8'd0) |-> (acc_out[22:0] == 23'd0));

endmodule

bind fp4_block_dot fp4_block_dot_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr       (clr),
   .in_valid  (in_valid),
   .a_scale   (a_scale),
   .b_scale   (b_scale),
   .acc_out   (acc_out),
   .acc_valid (acc_valid)
);

// File: tb/tb_fp4_block_dot.sv
`timescale 1ns/1ps
module tb_fp4_block_dot;

   localparam int N = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clr = 1'b0;
   logic          in_valid = 1'b0;
   logic [4*N-1:0] a_elems = '0;
   logic [4*N-1:0] b_elems = '0;
   logic [7:0]    a_scale = 8'h38;
   logic [7:0]    b_scale = 8'h38;
   logic [31:0]   acc_out;
   logic          acc_valid;

   int    n_tests = 0;
   int    n_fail  = 0;
   bit    done    = 1'b0;
   string cur_req = "R9";
   string m_tag   = "R9";

   logic [31:0] m_acc = 32'h0;
   logic        m_vld = 1'b0;

   always #5 clk = ~clk;

   fp4_block_dot #(.NUM_ELEM(N)) dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
      .a_elems(a_elems), .b_elems(b_elems), .a_scale(a_scale), .b_scale(b_scale),
      .acc_out(acc_out), .acc_valid(acc_valid)
   );

   function automatic real pow2(input int n);
      real r;
      r = 1.0;
      if (n >= 0) repeat (n) r = r * 2.0;
      else        repeat (-n) r = r / 2.0;
      return r;
   endfunction

   function automatic real fp4_val(input logic [3:0] c);
      real v;
      int  e;
      e = int'(c[2:1]);
      if (e == 0) v = (c[0] ? 0.5 : 0.0);
      else        v = (c[0] ? 1.5 : 1.0) * pow2(e - 1);
      return c[3] ? -v : v;
   endfunction

   function automatic real scale_val(input logic [7:0] c);
      real v;
      int  e;
      e = int'(c[6:3]);
      if (e == 0) v = (real'(c[2:0]) / 8.0) * pow2(-6);
      else        v = (1.0 + real'(c[2:0]) / 8.0) * pow2(e - 7);
      return c[7] ? -v : v;
   endfunction

   function automatic real f32_to_real(input logic [31:0] f);
      real v;
      if (f[30:23] == 8'd0) v = real'(f[22:0]) * pow2(-149);
      else v = (8388608.0 + real'(f[22:0])) * pow2(int'(f[30:23]) - 150);
      return f[31] ? -v : v;
   endfunction

   function automatic logic [31:0] real_to_f32(input real r);
      logic [63:0] d;
      int          de;
      logic [52:0] m53;
      logic [28:0] rem;
      logic [24:0] m25;
      logic        up;
      if (r == 0.0) return 32'h0;
      d   = $realtobits(r);
      de  = int'(d[62:52]) - 1023;
      m53 = {1'b1, d[51:0]};
      rem = m53[28:0];
      up  = (rem > 29'h1000_0000) || ((rem == 29'h1000_0000) && m53[29]);
      m25 = {1'b0, m53[52:29]} + 25'(up);
      if (m25[24]) begin
         de  = de + 1;
         m25 = m25 >> 1;
      end
      if (de > 127)  return {d[63], 8'hFF, 23'h0};
      if (de < -126) return 32'h0;
      return {d[63], 8'(de + 127), m25[22:0]};
   endfunction

   function automatic logic [31:0] model_step(input logic [31:0] base);
      real blk;
      if ((&a_scale[6:0]) || (&b_scale[6:0])) return 32'h7FC0_0000;
      if (base[30:23] == 8'hFF) return (base[22:0] != 0) ? 32'h7FC0_0000 : base;
      blk = 0.0;
      for (int i = 0; i < N; i++) blk = blk + fp4_val(a_elems[4*i +: 4]) * fp4_val(b_elems[4*i +: 4]);
      blk = blk * scale_val(a_scale) * scale_val(b_scale);
      return real_to_f32(f32_to_real(base) + blk);
   endfunction

   // reference model, updated at every rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_acc = 32'h0;
         m_vld = 1'b0;
      end else begin
         m_tag = cur_req;
         m_vld = in_valid;
         if (in_valid)  m_acc = model_step(clr ? 32'h0 : m_acc);
         else if (clr)  m_acc = 32'h0;
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_tests++;
         if (acc_out !== m_acc || acc_valid !== m_vld) begin
            n_fail++;
            $display("FAIL %s model: acc_out=%h acc_valid=%b expected %h %b",
                     m_tag, acc_out, acc_valid, m_acc, m_vld);
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic apply(input logic c, input logic v, input logic [4*N-1:0] a,
                        input logic [4*N-1:0] b, input logic [7:0] sa,
                        input logic [7:0] sb, input string tag);
      clr = c; in_valid = v; a_elems = a; b_elems = b;
      a_scale = sa; b_scale = sb; cur_req = tag;
      @(negedge clk);
      clr = 1'b0; in_valid = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9 acc", acc_out, 32'h0);
      chk("R9 valid", {31'h0, acc_valid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R5: restart with 6*6 -> 36.0
      apply(1, 1, (4*N)'(4'h7), (4*N)'(4'h7), 8'h38, 8'h38, "R5");
      chk("R5 restart", acc_out, 32'h4210_0000);
      chk("R6 valid pulse", {31'h0, acc_valid}, 32'h1);
      // R1: -0.5*0.5 added -> 35.75
      apply(0, 1, (4*N)'(4'h9), (4*N)'(4'h1), 8'h38, 8'h38, "R1");
      chk("R1 sign", acc_out, 32'h420F_0000);
      // R5: clear alone
      apply(1, 0, '0, '0, 8'h38, 8'h38, "R5");
      chk("R5 clear", acc_out, 32'h0);
      chk("R6 no valid", {31'h0, acc_valid}, 32'h0);
      // R6: idle hold
      apply(0, 1, (4*N)'(4'h7), (4*N)'(4'h7), 8'h38, 8'h38, "R6");
      apply(0, 0, (4*N)'(4'h7), (4*N)'(4'h7), 8'h38, 8'h38, "R6");
      chk("R6 hold", acc_out, 32'h4210_0000);
      // R3: subnormal scale 2^-9, 0.5*0.5 -> 2^-11
      apply(1, 1, (4*N)'(4'h1), (4*N)'(4'h1), 8'h01, 8'h38, "R3");
      chk("R3 subnormal scale", acc_out, 32'h3A00_0000);
      // R3: negative scale
      apply(1, 1, (4*N)'(4'h7), (4*N)'(4'h7), 8'hB8, 8'h38, "R3");
      chk("R3 negative scale", acc_out, 32'hC210_0000);
      // R2: all 16 lanes 6*6 -> 576
      apply(1, 1, {N{4'h7}}, {N{4'h7}}, 8'h38, 8'h38, "R2");
      chk("R2 full sum", acc_out, 32'h4410_0000);
      // R4: 2^24, then +1 ties to even, then +3 rounds up to even
      apply(1, 1, {N{4'h6}}, {N{4'h6}}, 8'h78, 8'h78, "R4");
      chk("R4 big", acc_out, 32'h4B80_0000);
      apply(0, 1, (4*N)'(4'h2), (4*N)'(4'h2), 8'h38, 8'h38, "R4");
      chk("R4 tie down", acc_out, 32'h4B80_0000);
      apply(0, 1, (4*N)'(4'h3), (4*N)'(4'h4), 8'h38, 8'h38, "R4");
      chk("R4 tie up", acc_out, 32'h4B80_0002);
      // R8: cancellation gives +0
      apply(1, 1, (4*N)'(4'h7), (4*N)'(4'h7), 8'h38, 8'h38, "R8");
      apply(0, 1, (4*N)'(4'hF), (4*N)'(4'h7), 8'h38, 8'h38, "R8");
      chk("R8 cancel", acc_out, 32'h0);
      // R8: negative-zero lanes
      apply(1, 1, {N{4'h8}}, {N{4'h7}}, 8'h38, 8'h38, "R8");
      chk("R8 neg zero block", acc_out, 32'h0);
      apply(0, 1, (4*N)'(4'h7), (4*N)'(4'h7), 8'h38, 8'h38, "R8");
      apply(0, 1, {N{4'h8}}, {N{4'h7}}, 8'hB8, 8'h38, "R8");
      chk("R8 zero block keeps", acc_out, 32'h4210_0000);
      // R7: NaN scale sticks until clear
      apply(0, 1, (4*N)'(4'h7), (4*N)'(4'h7), 8'h7F, 8'h38, "R7");
      chk("R7 nan", acc_out, 32'h7FC0_0000);
      apply(0, 1, (4*N)'(4'h7), (4*N)'(4'h7), 8'h38, 8'h38, "R7");
      chk("R7 nan sticky", acc_out, 32'h7FC0_0000);
      apply(1, 1, (4*N)'(4'h7), (4*N)'(4'h7), 8'h38, 8'h38, "R7");
      chk("R7 nan cleared", acc_out, 32'h4210_0000);

      // R4: random traffic against the model
      for (int k = 0; k < 400; k++) begin
         logic [4*N-1:0] ra;
         logic [4*N-1:0] rb;
         logic [7:0]     sa;
         logic [7:0]     sb;
         ra = {$urandom, $urandom};
         rb = {$urandom, $urandom};
         sa = 8'($urandom);
         sb = 8'($urandom);
         if ((&sa[6:0]) && ($urandom % 8 != 0)) sa[0] = 1'b0;
         if ((&sb[6:0]) && ($urandom % 8 != 0)) sb[0] = 1'b0;
         apply(($urandom % 10) == 0, ($urandom % 4) != 0, ra, rb, sa, sb, "R4");
      end
      @(negedge clk);
      finish_run();
   end

endmodule